// File: doc/BRIEF.md
# Watchdog and Power-On Reset Generator

This block produces the active-low internal reset of a small controller from three causes: the supply coming up, an active-low external reset pin, and a watchdog that nobody refreshed in time. After the supply-good input rises, the internal reset is held for a fixed power-on delay. It is released only when that delay has run out and the synchronised external pin is high. Once the reset is released, the processor starts fetching at its fixed start address.

The watchdog cannot be switched off. It starts counting by itself on the first clock after the internal reset is released. A one-cycle kick strobe, raised by the processor when it executes its refresh opcode, restarts the window. If a whole window passes without a kick, the block drives a separate active-low pulse of fixed width. A board may wire that pulse back to the external reset pin.

A hot-start flag separates a watchdog restart from a power-up. The flag is 0 after power-up and is set by every timeout. A read strobe clears it, and it survives every reset except power-on. All time constants are parameters counted in system clock cycles.

Top module: `wdog_reset_unit`

## Requirements
- R1: While `pwr_ok_n` is low, `sys_rst_n` is 0, `wdt_out_n` is 1 and `hot_start` is 0.
- R2: With `ext_rst_n` held high, `sys_rst_n` rises on the (POR_CYCLES+1)-th rising clock edge after `pwr_ok_n` goes high.
- R3: A low level on `ext_rst_n` pulls `sys_rst_n` low on the (SYNC_STAGES+1)-th edge after the level is applied. Release takes the same number of edges. External reset neither restarts the power-on delay nor touches the hot-start flag.
- R4: With no kick, `wdt_out_n` falls on the WINDOW_CYCLES-th rising edge after the later of two edges: the edge at which `sys_rst_n` rose, or the last edge at which `kick` was sampled high. Kicks spaced closer than the window keep `wdt_out_n` high.
- R5: Each timeout holds `wdt_out_n` low for exactly PULSE_CYCLES clock cycles, then returns it high.
- R6: A kick sampled on the edge where the window would expire wins. No pulse follows, and the window restarts from that edge.
- R7: `hot_start` becomes 1 on the edge where `wdt_out_n` falls. It clears on the edge after `hot_rd` is sampled high. If a read and a timeout fall on the same edge, the flag stays 1.
- R8: `hot_start` is cleared only by power-on. External and watchdog-looped resets keep it.
- R9: While `sys_rst_n` is low the watchdog is held cleared, so no timeout pulse can start, however long the reset lasts.
- R10: When `wdt_out_n` is looped back to `ext_rst_n`, the pulse still lasts its full PULSE_CYCLES, and `sys_rst_n` is released again after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_ok_n | input | 1 | Power-on indication, low while the supply is not yet valid; asynchronous clear of all state |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| kick | input | 1 | One-cycle watchdog refresh strobe |
| hot_rd | input | 1 | One-cycle strobe marking a processor read of the hot-start flag |
| sys_rst_n | output | 1 | Internal reset, active low, registered |
| wdt_out_n | output | 1 | Watchdog timeout pulse, active low |
| hot_start | output | 1 | 1 when the last start came from a watchdog timeout |

## Verification
The bench builds the block with POR_CYCLES=20, WINDOW_CYCLES=40, PULSE_CYCLES=6 and SYNC_STAGES=2. With these values the power-on release, several complete timeouts and their pulses fit into a few hundred clocks, where the real millisecond constants would need millions of cycles. Because the values are small, the bench can place a kick exactly on the terminal edge, hold external reset for several windows, and run the loop-back case in which the pulse resets its own source. It can also line up a flag read with the timeout edge.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

   // Counter width able to hold values 0 .. n-1 (at least one bit).
   function automatic int cnt_w(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wdr_sync_chain.sv
module wdr_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("wdr_sync_chain: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge clr_n) begin
         if (!clr_n) sh_q <= '0;
         else if (STAGES == 1) sh_q <= d_i;
         else sh_q <= {sh_q[STAGES-2:0], d_i};
      end
      assign q_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/wdr_por_timer.sv
module wdr_por_timer #(
   parameter int DELAY_CYCLES = 750000
) (
   input  logic clk,
   input  logic pwr_ok_n,
   output logic done_o
);

   localparam int CW = wdr_pkg::cnt_w(DELAY_CYCLES + 1);

   if (DELAY_CYCLES < 0) begin : g_bad_delay
      $error("wdr_por_timer: DELAY_CYCLES must not be negative");
   end

   if (DELAY_CYCLES == 0) begin : g_no_delay
      assign done_o = 1'b1;
   end else begin : g_count
      localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge pwr_ok_n) begin
         if (!pwr_ok_n) cnt_q <= '0;
         else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign done_o = (cnt_q == LIMIT);

      // Once the delay has run out it never comes back before the next power-up.
      AST_POR_DONE_STICKY: assert property (@(posedge clk) disable iff (!pwr_ok_n)
         done_o |=> done_o) else $error("power-on done dropped");  // R2
   end

endmodule

// File: rtl/wdr_wdog_core.sv
module wdr_wdog_core #(
   parameter int WINDOW_CYCLES = 250000,
   parameter int PULSE_CYCLES  = 50
) (
   input  logic clk,
   input  logic pwr_ok_n,
   input  logic run_i,
   input  logic kick_i,
   output logic expire_o,
   output logic wdt_n_o
);

   localparam int WW = wdr_pkg::cnt_w(WINDOW_CYCLES);
   localparam int PW = wdr_pkg::cnt_w(PULSE_CYCLES + 1);
   localparam logic [WW-1:0] W_LAST = WW'(WINDOW_CYCLES - 1);
   localparam logic [PW-1:0] P_LEN  = PW'(PULSE_CYCLES);
   localparam logic [PW-1:0] P_ONE  = PW'(1);

   if (WINDOW_CYCLES < 2) begin : g_bad_window
      $error("wdr_wdog_core: WINDOW_CYCLES must be at least 2");
   end
   if (PULSE_CYCLES < 1 || PULSE_CYCLES >= WINDOW_CYCLES) begin : g_bad_pulse
      $error("wdr_wdog_core: PULSE_CYCLES must lie in 1 .. WINDOW_CYCLES-1");
   end

   logic [WW-1:0] win_q;
   logic [PW-1:0] pls_q;
   logic          at_end;

   assign at_end   = (win_q == W_LAST);
   assign expire_o = run_i & ~kick_i & at_end;

   // Window counter: cleared while the chip is in reset, on a kick, and on expiry.
   always_ff @(posedge clk or negedge pwr_ok_n) begin
      if (!pwr_ok_n)                  win_q <= '0;
      else if (!run_i || kick_i || at_end) win_q <= '0;
      else                            win_q <= win_q + 1'b1;
   end

   // Pulse stretcher: cleared only by power-on, so a looped-back reset cannot cut it short.
   always_ff @(posedge clk or negedge pwr_ok_n) begin
      if (!pwr_ok_n)       pls_q <= '0;
      else if (expire_o)   pls_q <= P_LEN;
      else if (pls_q != '0) pls_q <= pls_q - 1'b1;
   end

   assign wdt_n_o = (pls_q == '0);

   AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      !run_i |=> (win_q == '0)) else $error("window counted during reset");  // R9
   AST_NO_PULSE_FROM_RESET: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      $fell(wdt_n_o) |-> $past(run_i)) else $error("pulse started in reset");  // R9
   AST_KICK_WINS: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      (kick_i && wdt_n_o) |=> wdt_n_o) else $error("pulse despite kick");  // R6
   AST_PULSE_SHRINKS: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      (pls_q > P_ONE) |=> (pls_q == $past(pls_q) - P_ONE)) else $error("pulse restarted");  // R5

endmodule

// File: rtl/wdog_reset_unit.sv
module wdog_reset_unit #(
   parameter int POR_CYCLES    = 750000,
   parameter int WINDOW_CYCLES = 250000,
   parameter int PULSE_CYCLES  = 50,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic pwr_ok_n,
   input  logic ext_rst_n,
   input  logic kick,
   input  logic hot_rd,
   output logic sys_rst_n,
   output logic wdt_out_n,
   output logic hot_start
);

   logic por_done;
   logic ext_ok;
   logic rst_q;
   logic expire;
   logic hot_q;

   wdr_por_timer #(.DELAY_CYCLES(POR_CYCLES)) u_por (
      .clk      (clk),
      .pwr_ok_n (pwr_ok_n),
      .done_o   (por_done)
   );

   wdr_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr_n (pwr_ok_n),
      .d_i   (ext_rst_n),
      .q_o   (ext_ok)
   );

   always_ff @(posedge clk or negedge pwr_ok_n) begin
      if (!pwr_ok_n) rst_q <= 1'b0;
      else           rst_q <= por_done & ext_ok;
   end

   wdr_wdog_core #(.WINDOW_CYCLES(WINDOW_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_wd (
      .clk      (clk),
      .pwr_ok_n (pwr_ok_n),
      .run_i    (rst_q),
      .kick_i   (kick),
      .expire_o (expire),
      .wdt_n_o  (wdt_out_n)
   );

   // Hot-start flag: a timeout beats a read on the same edge.
   always_ff @(posedge clk or negedge pwr_ok_n) begin
      if (!pwr_ok_n)   hot_q <= 1'b0;
      else if (expire) hot_q <= 1'b1;
      else if (hot_rd) hot_q <= 1'b0;
   end

   assign sys_rst_n = rst_q;
   assign hot_start = hot_q;

   AST_HOT_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      $fell(wdt_out_n) |-> hot_start) else $error("timeout without hot flag");  // R7
   AST_HOT_NEEDS_READ: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      $fell(hot_start) |-> $past(hot_rd)) else $error("hot flag lost without read");  // R8
   AST_POR_HOLDS_RESET: assert property (@(posedge clk) disable iff (!pwr_ok_n)
      !por_done |=> !sys_rst_n) else $error("reset released early");  // R2

endmodule

// File: tb/sim_wdog_reset_unit.sv
`timescale 1ns/1ps
module sim_wdog_reset_unit;

   localparam int P = 20;
   localparam int W = 40;
   localparam int L = 6;
   localparam int S = 2;

   logic clk = 1'b0;
   logic pwr_ok_n = 1'b0;
   logic ext_drv = 1'b1;
   logic loop_en = 1'b0;
   logic kick = 1'b0;
   logic hot_rd = 1'b0;
   logic ext_rst_n;
   logic sys_rst_n, wdt_out_n, hot_start;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit cmp_en = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   assign ext_rst_n = loop_en ? wdt_out_n : ext_drv;

   wdog_reset_unit #(.POR_CYCLES(P), .WINDOW_CYCLES(W), .PULSE_CYCLES(L), .SYNC_STAGES(S)) u0 (
      .clk(clk), .pwr_ok_n(pwr_ok_n), .ext_rst_n(ext_rst_n), .kick(kick), .hot_rd(hot_rd),
      .sys_rst_n(sys_rst_n), .wdt_out_n(wdt_out_n), .hot_start(hot_start));

   // Behavioural reference model
   int m_por, m_win, m_pls;
   bit m_rst, m_hot;
   bit m_sync[$];
   always @(posedge clk or negedge pwr_ok_n) begin
      if (!pwr_ok_n) begin
         m_por = 0; m_win = 0; m_pls = 0; m_rst = 0; m_hot = 0;
         m_sync = {};
         for (int i = 0; i < S; i++) m_sync.push_back(1'b0);
      end else begin
         bit ext_now, exp_now, rst_old;
         ext_now = loop_en ? (m_pls == 0) : ext_drv;
         rst_old = m_rst;
         m_rst = (m_por == P) && m_sync[S-1];
         if (m_por < P) m_por++;
         m_sync.push_front(ext_now); void'(m_sync.pop_back());
         exp_now = rst_old && !kick && (m_win == W-1);
         if (!rst_old || kick || m_win == W-1) m_win = 0; else m_win++;
         if (exp_now) m_pls = L; else if (m_pls > 0) m_pls--;
         if (exp_now) m_hot = 1; else if (hot_rd) m_hot = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Every-clock comparison against the model (R1 R2 R3 R4 R5 R7 R9 R10)
   always @(negedge clk) begin
      cyc++;
      if (cmp_en) begin
         check(sys_rst_n == m_rst, "R2 R3 R9 sys_rst_n vs model", sys_rst_n, m_rst);
         check(wdt_out_n == (m_pls == 0), "R4 R5 R10 wdt_out_n vs model", wdt_out_n, m_pls == 0);
         check(hot_start == m_hot, "R7 R8 hot_start vs model", hot_start, m_hot);
      end
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: bench hung");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_kick();
      kick = 1'b1; @(negedge clk); kick = 1'b0;
   endtask

   task automatic do_read();
      hot_rd = 1'b1; @(negedge clk); hot_rd = 1'b0;
   endtask

   // Count negedges until wdt_out_n is low (after a kick or release edge already passed).
   task automatic wait_low(output int n);
      n = 0;
      while (wdt_out_n && n < 10*W) begin @(negedge clk); n++; end
   endtask

   task automatic measure_pulse(output int n);
      n = 0;
      while (!wdt_out_n && n < 10*L) begin @(negedge clk); n++; end
   endtask

   initial begin
      int n;
      cycles(5);
      check(sys_rst_n == 0, "R1 reset sys_rst_n", sys_rst_n, 0);
      check(wdt_out_n == 1, "R1 reset wdt_out_n", wdt_out_n, 1);
      check(hot_start == 0, "R1 reset hot_start", hot_start, 0);
      cmp_en = 1'b1;

      // R2: power-on delay
      pwr_ok_n = 1'b1;
      n = 0;
      while (!sys_rst_n && n < 5*P) begin @(negedge clk); n++; end
      check(n == P+1, "R2 power-on release edge", n, P+1);

      // R4: regular kicks keep the pulse away
      for (int k = 0; k < 6; k++) begin cycles(W/2); do_kick(); end
      check(wdt_out_n == 1, "R4 no timeout with kicks", wdt_out_n, 1);

      // R4 R5 R7: timeout after the last kick
      do_kick();
      wait_low(n);
      check(n == W, "R4 timeout edge after kick", n, W);
      check(hot_start == 1, "R7 hot flag set on timeout", hot_start, 1);
      measure_pulse(n);
      check(n == L, "R5 pulse width", n, L);

      // R7: read clears
      do_read();
      check(hot_start == 0, "R7 hot flag cleared by read", hot_start, 0);

      // R6: kick on the terminal edge
      do_kick();
      cycles(W-1);
      do_kick();
      cycles(3);
      check(wdt_out_n == 1, "R6 kick on terminal edge wins", wdt_out_n, 1);
      check(hot_start == 0, "R6 no hot flag after winning kick", hot_start, 0);
      wait_low(n);
      check(n == W-3, "R6 window restarted from kick", n, W-3);
      measure_pulse(n);

      // R3 R8 R9: long external reset keeps hot flag, no pulse
      ext_drv = 1'b0;
      cycles(S+1);
      check(sys_rst_n == 0, "R3 external reset asserts", sys_rst_n, 0);
      cycles(3*W);
      check(wdt_out_n == 1, "R9 no pulse during reset", wdt_out_n, 1);
      check(hot_start == 1, "R8 hot flag kept over external reset", hot_start, 1);
      ext_drv = 1'b1;
      n = 0;
      while (!sys_rst_n && n < 10) begin @(negedge clk); n++; end
      check(n == S+1, "R3 external release latency", n, S+1);

      // R7: read on the same edge as a timeout keeps the flag
      do_read();
      hot_rd = 1'b1;
      wait_low(n);
      check(hot_start == 1, "R7 timeout beats simultaneous read", hot_start, 1);
      hot_rd = 1'b0;
      measure_pulse(n);

      // R10: loop-back
      loop_en = 1'b1;
      wait_low(n);
      measure_pulse(n);
      check(n == L, "R10 full pulse with loop-back", n, L);
      cycles(S+2);
      check(sys_rst_n == 1, "R10 reset released after pulse", sys_rst_n, 1);
      check(hot_start == 1, "R8 hot flag kept over watchdog reset", hot_start, 1);
      loop_en = 1'b0;

      // R1 R8: power-on clears the flag
      cmp_en = 1'b0;
      pwr_ok_n = 1'b0;
      cycles(2);
      check(hot_start == 0, "R8 power-on clears hot flag", hot_start, 0);
      check(sys_rst_n == 0, "R1 power-on asserts reset", sys_rst_n, 0);
      cycles(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule